// File: doc/BRIEF.md
# Register File Block Partition Allocator

This block hands out regions of a multiprocessor register file to thread blocks as they launch. The file holds 8192 four-byte words by default. A launch request gives a thread count and a per-thread register count. The allocator multiplies them to get the block's demand in words. It then searches the current layout for the lowest-addressed contiguous free stretch that can hold the whole demand. If one exists, it claims the lowest idle slot number, records the region, and reports the base word index together with that slot. If none exists, it reports a rejection and changes nothing.

Freeing a slot removes its region. Free space is defined as whatever lies between live regions, so a freed region joins any free space on either side at once. A third port checks the fence around each region. It takes a slot number and a register index, and it flags a violation unless that slot is live and the index lies inside that slot's region.

Top module: `regfile_part_alloc`

## Requirements
- R1: An admitted block gets a region of exactly threads × registers-per-thread words starting at the reported base.
- R2: A launch request is taken when both alloc_valid and alloc_ready are high on a clock edge.
  - alloc_ready is low during the following cycle.
  - res_valid is high for exactly one cycle, two clock edges after the accepting edge.
- R3: When a block is admitted, the base is the lowest word index at which `demand` consecutive free words lie within capacity. The slot is the lowest-numbered slot not currently live.
- R4: The request is rejected with res_ok = 0 in any of these cases:
  - the demand is zero;
  - the demand exceeds the capacity;
  - all slots are live;
  - no free stretch is long enough.
  A rejection leaves every region as it was.
- R5: A release on rel_valid frees that slot's region at the next edge. The freed words merge with free neighbours into one stretch, so later requests may span them. Releasing a slot that is not live has no effect.
- R6: A check on chk_valid answers on the next cycle with chk_resp_valid = 1. chk_violation is 1 when the slot is not live, when the index is below the slot's base, or when the index is at or beyond base + size. Otherwise chk_violation is 0.
- R7: With 8192 words, three blocks of 256 threads × 10 registers are admitted and a fourth is rejected. With 256 × 11, only two are admitted.
- R8: After reset, alloc_ready is 1, res_valid and chk_resp_valid are 0, and no slot is live.
- R9: Live regions never overlap, and each lies wholly below the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| alloc_valid | input | 1 | Launch request present |
| alloc_ready | output | 1 | Launch request can be taken |
| alloc_threads | input | 10 | Threads in the block |
| alloc_rpt | input | 8 | Registers per thread |
| res_valid | output | 1 | Allocation result pulse |
| res_ok | output | 1 | 1 admitted, 0 rejected |
| res_base | output | 13 | First word of the admitted region |
| res_slot | output | 3 | Slot given to the admitted block |
| rel_valid | input | 1 | Release request |
| rel_ready | output | 1 | Release can be taken (high out of reset) |
| rel_slot | input | 3 | Slot to free |
| chk_valid | input | 1 | Access check request |
| chk_ready | output | 1 | Check can be taken (high out of reset) |
| chk_slot | input | 3 | Slot claiming the access |
| chk_index | input | 13 | Register word index accessed |
| chk_resp_valid | output | 1 | Check answer present |
| chk_violation | output | 1 | Access falls outside the slot's live region |

## Verification
The assertions take for granted two things about the inputs. First, a launch is only presented while alloc_ready is high. Second, a release never targets the slot that the in-flight launch is about to claim in the same cycle. The stimulus meets both by running one operation at a time: each launch is waited out until its result pulse has come and gone, and a release or check starts only after that. Random thread and register counts deliberately push demands past the capacity and past the free space. Release targets are drawn from all slots, so idle ones are freed too.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  localparam int unsigned RFA_WORDS = 8192;
  localparam int unsigned RFA_SLOTS = 8;
  localparam int unsigned RFA_THR_W = 10;
  localparam int unsigned RFA_RPT_W = 8;

  function automatic int unsigned rfa_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rfa_demand.sv
module rfa_demand #(
  parameter int unsigned THR_W = 10,
  parameter int unsigned RPT_W = 8,
  localparam int unsigned DEM_W = THR_W + RPT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [THR_W-1:0] threads,
  input  logic [RPT_W-1:0] rpt,
  output logic             dem_v,
  output logic [DEM_W-1:0] dem
);
  logic [DEM_W-1:0] dem_d;

  always_comb begin
    dem_d = DEM_W'(threads) * DEM_W'(rpt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dem_v <= 1'b0;
      dem   <= '0;
    end else begin
      dem_v <= take;
      if (take) dem <= dem_d;
    end
  end
endmodule

// File: rtl/rfa_fit.sv
module rfa_fit #(
  parameter int unsigned WORDS = 8192,
  parameter int unsigned SLOTS = 8,
  parameter int unsigned DEM_W = 18,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned SZ_W = IDX_W + 1,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned AW = rfa_pkg::rfa_max(DEM_W, SZ_W) + 1
) (
  input  logic [SLOTS-1:0]            live,
  input  logic [SLOTS-1:0][IDX_W-1:0] base,
  input  logic [SLOTS-1:0][SZ_W-1:0]  size,
  input  logic [DEM_W-1:0]            dem,
  output logic                        fit_ok,
  output logic [IDX_W-1:0]            fit_base,
  output logic [SLOT_W-1:0]           fit_slot
);
  localparam logic [AW-1:0] CAP_A = AW'(WORDS);

  logic [SLOTS:0][AW-1:0] cand;
  logic [SLOTS:0][AW-1:0] cand_end;
  logic [SLOTS:0]         cand_use;
  logic [SLOTS:0]         good;
  logic [SLOTS-1:0][AW-1:0] reg_lo;
  logic [SLOTS-1:0][AW-1:0] reg_hi;

  genvar k;
  generate
    for (k = 0; k < SLOTS; k++) begin : g_reg
      assign reg_lo[k] = AW'(base[k]);
      assign reg_hi[k] = AW'(base[k]) + AW'(size[k]);
    end
    for (k = 0; k <= SLOTS; k++) begin : g_cand
      if (k == 0) begin : g_zero
        assign cand[k]     = '0;
        assign cand_use[k] = 1'b1;
      end else begin : g_after
        assign cand[k]     = reg_hi[k-1];
        assign cand_use[k] = live[k-1];
      end
      assign cand_end[k] = cand[k] + AW'(dem);
      always_comb begin
        logic clash;
        clash = 1'b0;
        for (int j = 0; j < SLOTS; j++) begin
          if (live[j] && (cand[k] < reg_hi[j]) && (reg_lo[j] < cand_end[k])) clash = 1'b1;
        end
        good[k] = cand_use[k] && (cand_end[k] <= CAP_A) && !clash;
      end
    end
  endgenerate

  logic          found;
  logic [AW-1:0] best;
  logic          any_free;
  logic [SLOT_W-1:0] free_slot;

  always_comb begin
    found = 1'b0;
    best  = '0;
    for (int c = 0; c <= SLOTS; c++) begin
      if (good[c] && (!found || cand[c] < best)) begin
        found = 1'b1;
        best  = cand[c];
      end
    end
  end

  always_comb begin
    any_free  = 1'b0;
    free_slot = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (!live[i]) begin
        any_free  = 1'b1;
        free_slot = SLOT_W'(i);
      end
    end
  end

  assign fit_ok   = found && any_free && (dem != '0);
  assign fit_base = best[IDX_W-1:0];
  assign fit_slot = free_slot;
endmodule

// File: rtl/rfa_table.sv
module rfa_table #(
  parameter int unsigned WORDS = 8192,
  parameter int unsigned SLOTS = 8,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned SZ_W = IDX_W + 1,
  localparam int unsigned SLOT_W = $clog2(SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [SLOT_W-1:0]           wr_slot,
  input  logic [IDX_W-1:0]            wr_base,
  input  logic [SZ_W-1:0]             wr_size,
  input  logic                        rel_en,
  input  logic [SLOT_W-1:0]           rel_slot,
  input  logic                        chk_en,
  input  logic [SLOT_W-1:0]           chk_slot,
  input  logic [IDX_W-1:0]            chk_idx,
  output logic [SLOTS-1:0]            live,
  output logic [SLOTS-1:0][IDX_W-1:0] base,
  output logic [SLOTS-1:0][SZ_W-1:0]  size,
  output logic                        chk_rvalid,
  output logic                        chk_viol
);
  logic [SLOTS-1:0] live_d;
  logic [SZ_W-1:0]  chk_end;
  logic             viol_d;

  always_comb begin
    live_d = live;
    if (rel_en) live_d[rel_slot] = 1'b0;
    if (wr_en)  live_d[wr_slot]  = 1'b1;
  end

  always_comb begin
    chk_end = SZ_W'(base[chk_slot]) + size[chk_slot];
    viol_d  = !live[chk_slot] || (chk_idx < base[chk_slot]) || (SZ_W'(chk_idx) >= chk_end);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      base <= '0;
      size <= '0;
    end else begin
      live <= live_d;
      if (wr_en) begin
        base[wr_slot] <= wr_base;
        size[wr_slot] <= wr_size;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_rvalid <= 1'b0;
      chk_viol   <= 1'b0;
    end else begin
      chk_rvalid <= chk_en;
      if (chk_en) chk_viol <= viol_d;
    end
  end

  logic [SLOTS-1:0][SZ_W:0] slot_end;

  genvar i, j;
  generate
    for (i = 0; i < SLOTS; i++) begin : g_slot_a
      assign slot_end[i] = (SZ_W+1)'(base[i]) + (SZ_W+1)'(size[i]);
      // R9
      in_capacity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live[i] |-> (slot_end[i] <= (SZ_W+1)'(WORDS)));
      for (j = i + 1; j < SLOTS; j++) begin : g_pair
        // R9
        no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (live[i] && live[j]) |->
            ((slot_end[i] <= (SZ_W+1)'(base[j])) || (slot_end[j] <= (SZ_W+1)'(base[i]))));
      end
    end
  endgenerate

  // R3
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !live[wr_slot]);

  // R6
  dead_slot_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en && !live[chk_slot]) |=> (chk_rvalid && chk_viol));
endmodule

// File: rtl/regfile_part_alloc.sv
module regfile_part_alloc #(
  parameter int unsigned WORDS = rfa_pkg::RFA_WORDS,
  parameter int unsigned SLOTS = rfa_pkg::RFA_SLOTS,
  parameter int unsigned THR_W = rfa_pkg::RFA_THR_W,
  parameter int unsigned RPT_W = rfa_pkg::RFA_RPT_W,
  localparam int unsigned IDX_W = $clog2(WORDS),
  localparam int unsigned SZ_W = IDX_W + 1,
  localparam int unsigned SLOT_W = $clog2(SLOTS),
  localparam int unsigned DEM_W = THR_W + RPT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [THR_W-1:0]  alloc_threads,
  input  logic [RPT_W-1:0]  alloc_rpt,
  output logic              res_valid,
  output logic              res_ok,
  output logic [IDX_W-1:0]  res_base,
  output logic [SLOT_W-1:0] res_slot,
  input  logic              rel_valid,
  output logic              rel_ready,
  input  logic [SLOT_W-1:0] rel_slot,
  input  logic              chk_valid,
  output logic              chk_ready,
  input  logic [SLOT_W-1:0] chk_slot,
  input  logic [IDX_W-1:0]  chk_index,
  output logic              chk_resp_valid,
  output logic              chk_violation
);
  logic rs_q1, rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_n  <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_n  <= rs_q1;
    end
  end

  logic                        take;
  logic                        dem_v;
  logic [DEM_W-1:0]            dem;
  logic [SLOTS-1:0]            live;
  logic [SLOTS-1:0][IDX_W-1:0] base;
  logic [SLOTS-1:0][SZ_W-1:0]  size;
  logic                        fit_ok;
  logic [IDX_W-1:0]            fit_base;
  logic [SLOT_W-1:0]           fit_slot;
  logic                        wr_en;

  assign alloc_ready = rs_n && !dem_v;
  assign rel_ready   = rs_n;
  assign chk_ready   = rs_n;
  assign take        = alloc_valid && alloc_ready;
  assign wr_en       = dem_v && fit_ok;

  rfa_demand #(.THR_W(THR_W), .RPT_W(RPT_W)) u_dem (
    .clk(clk), .rst_n(rs_n), .take(take), .threads(alloc_threads), .rpt(alloc_rpt),
    .dem_v(dem_v), .dem(dem)
  );

  rfa_fit #(.WORDS(WORDS), .SLOTS(SLOTS), .DEM_W(DEM_W)) u_fit (
    .live(live), .base(base), .size(size), .dem(dem),
    .fit_ok(fit_ok), .fit_base(fit_base), .fit_slot(fit_slot)
  );

  rfa_table #(.WORDS(WORDS), .SLOTS(SLOTS)) u_tab (
    .clk(clk), .rst_n(rs_n),
    .wr_en(wr_en), .wr_slot(fit_slot), .wr_base(fit_base), .wr_size(dem[SZ_W-1:0]),
    .rel_en(rel_valid && rel_ready), .rel_slot(rel_slot),
    .chk_en(chk_valid && chk_ready), .chk_slot(chk_slot), .chk_idx(chk_index),
    .live(live), .base(base), .size(size),
    .chk_rvalid(chk_resp_valid), .chk_viol(chk_violation)
  );

  logic              res_ok_d;
  logic [IDX_W-1:0]  res_base_d;
  logic [SLOT_W-1:0] res_slot_d;

  always_comb begin
    res_ok_d   = res_ok;
    res_base_d = res_base;
    res_slot_d = res_slot;
    if (dem_v) begin
      res_ok_d   = fit_ok;
      res_base_d = fit_ok ? fit_base : '0;
      res_slot_d = fit_ok ? fit_slot : '0;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      res_valid <= 1'b0;
      res_ok    <= 1'b0;
      res_base  <= '0;
      res_slot  <= '0;
    end else begin
      res_valid <= dem_v;
      res_ok    <= res_ok_d;
      res_base  <= res_base_d;
      res_slot  <= res_slot_d;
    end
  end

  // R2
  alloc_latency_chk: assert property (@(posedge clk) disable iff (!rs_n)
    take |=> ##1 res_valid);
  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rs_n)
    take |=> !alloc_ready);
  // R2
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rs_n)
    res_valid |=> !res_valid);
  // R4
  zero_demand_reject_chk: assert property (@(posedge clk) disable iff (!rs_n)
    (dem_v && dem == '0) |=> !res_ok);
endmodule

// File: tb/regfile_part_alloc_test.sv
`timescale 1ns/1ps
module regfile_part_alloc_test;
  localparam int WORDS = 8192;
  localparam int SLOTS = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic [9:0] alloc_threads = '0;
  logic [7:0] alloc_rpt = '0;
  logic rel_valid = 1'b0;
  logic [2:0] rel_slot = '0;
  logic chk_valid = 1'b0;
  logic [2:0] chk_slot = '0;
  logic [12:0] chk_index = '0;
  logic alloc_ready, res_valid, res_ok, rel_ready, chk_ready, chk_resp_valid, chk_violation;
  logic [12:0] res_base;
  logic [2:0] res_slot;

  always #4 clk = ~clk;

  regfile_part_alloc uut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
    .alloc_threads(alloc_threads), .alloc_rpt(alloc_rpt), .res_valid(res_valid),
    .res_ok(res_ok), .res_base(res_base), .res_slot(res_slot), .rel_valid(rel_valid),
    .rel_ready(rel_ready), .rel_slot(rel_slot), .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_slot(chk_slot), .chk_index(chk_index), .chk_resp_valid(chk_resp_valid),
    .chk_violation(chk_violation)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit m_v [SLOTS];
  int m_base [SLOTS];
  int m_size [SLOTS];
  int last_ok_count;

  task automatic tally(input bit good, input string tag, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_fit(input int d, output bit ok, output int b, output int s);
    int a;
    bit hit;
    ok = 0; b = 0; s = -1;
    for (int i = SLOTS - 1; i >= 0; i--) if (!m_v[i]) s = i;
    if (d == 0 || d > WORDS || s < 0) return;
    a = 0;
    while (a + d <= WORDS) begin
      hit = 0;
      for (int j = 0; j < SLOTS; j++) begin
        if (!hit && m_v[j] && a < m_base[j] + m_size[j] && m_base[j] < a + d) begin
          hit = 1;
          a = m_base[j] + m_size[j];
        end
      end
      if (!hit) begin
        ok = 1; b = a;
        return;
      end
    end
  endtask

  task automatic do_alloc(input int thr, input int rpt, input string tag);
    bit eok; int eb, es;
    model_fit(thr * rpt, eok, eb, es);
    @(negedge clk);
    while (!alloc_ready) @(negedge clk);
    alloc_valid = 1; alloc_threads = 10'(thr); alloc_rpt = 8'(rpt);
    @(posedge clk); #1;
    alloc_valid = 0;
    tally(alloc_ready == 0, "R2 ready low after take", int'(alloc_ready), 0);
    tally(res_valid == 0, "R2 no early result", int'(res_valid), 0);
    @(posedge clk); #1;
    tally(res_valid == 1, "R2 result after two edges", int'(res_valid), 1);
    tally(res_ok == eok, {tag, " admit/reject"}, int'(res_ok), int'(eok));
    if (eok && res_ok) begin
      tally(int'(res_base) == eb, {tag, " R3 base"}, int'(res_base), eb);
      tally(int'(res_slot) == es, {tag, " R3 slot"}, int'(res_slot), es);
    end
    if (eok) begin
      m_v[es] = 1; m_base[es] = eb; m_size[es] = thr * rpt;
      last_ok_count++;
    end
    @(posedge clk); #1;
    tally(res_valid == 0, "R2 one-cycle pulse", int'(res_valid), 1'b0);
  endtask

  task automatic do_rel(input int s);
    @(negedge clk);
    rel_valid = 1; rel_slot = 3'(s);
    @(posedge clk); #1;
    rel_valid = 0;
    m_v[s] = 0;
  endtask

  task automatic do_chk(input int s, input int idx, input string tag);
    int ix; bit ev;
    ix = idx & (WORDS - 1);
    ev = !m_v[s] || ix < m_base[s] || ix >= m_base[s] + m_size[s];
    @(negedge clk);
    chk_valid = 1; chk_slot = 3'(s); chk_index = 13'(ix);
    @(posedge clk); #1;
    chk_valid = 0;
    tally(chk_resp_valid == 1, {tag, " response valid"}, int'(chk_resp_valid), 1);
    tally(chk_violation == ev, {tag, " violation"}, int'(chk_violation), int'(ev));
  endtask

  task automatic free_all();
    for (int i = 0; i < SLOTS; i++) do_rel(i);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    for (int i = 0; i < SLOTS; i++) begin m_v[i] = 0; m_base[i] = 0; m_size[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk); #1;
    // R8 reset state
    tally(alloc_ready == 1, "R8 ready out of reset", int'(alloc_ready), 1);
    tally(res_valid == 0, "R8 no result out of reset", int'(res_valid), 0);
    tally(chk_resp_valid == 0, "R8 no check response out of reset", int'(chk_resp_valid), 0);
    do_chk(0, 0, "R8 empty table");
    do_chk(7, 100, "R8 empty table");

    // R7 capacity examples
    last_ok_count = 0;
    for (int n = 0; n < 4; n++) do_alloc(256, 10, "R7 256x10");
    tally(last_ok_count == 3, "R7 blocks admitted at 10 regs", last_ok_count, 3);
    // R1 region extent for slot 1 (base 2560, 2560 words)
    do_chk(1, 2560, "R1 first word");
    do_chk(1, 5119, "R1 last word");
    do_chk(1, 5120, "R1 one past end");
    do_chk(1, 2559, "R6 below base");
    do_chk(0, 3000, "R6 other slot region");
    free_all();
    last_ok_count = 0;
    for (int n = 0; n < 3; n++) do_alloc(256, 11, "R7 256x11");
    tally(last_ok_count == 2, "R7 blocks admitted at 11 regs", last_ok_count, 2);
    free_all();

    // R4 reject cases
    do_alloc(0, 5, "R4 zero demand");
    do_alloc(512, 20, "R4 over capacity");
    do_alloc(512, 16, "R4 exact capacity");
    do_alloc(1, 1, "R4 full file");
    free_all();
    for (int n = 0; n < 9; n++) do_alloc(64, 2, "R4 slot exhaustion");
    do_chk(0, 0, "R4 table unchanged by reject");
    free_all();

    // R5 merge of freed neighbours
    do_alloc(40, 25, "R5 A");
    do_alloc(40, 25, "R5 B");
    do_alloc(40, 25, "R5 C");
    do_rel(1);
    do_chk(1, 1200, "R5 freed slot");
    do_alloc(60, 25, "R5 no fit in 1000 gap");
    do_rel(0);
    do_alloc(72, 25, "R5 merged 0..2000 stretch");
    do_rel(6);
    do_chk(0, 10, "R5 release of idle slot ignored");
    free_all();

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op, s, pick, idx;
      op = $urandom_range(0, 2);
      if (op == 0) begin
        do_alloc(32 * $urandom_range(0, 16), $urandom_range(1, 24), "R1 R3 R4 random");
      end else if (op == 1) begin
        do_rel($urandom_range(0, SLOTS - 1));
      end else begin
        s = $urandom_range(0, SLOTS - 1);
        pick = $urandom_range(0, 4);
        case (pick)
          0: idx = m_base[s] - 1;
          1: idx = m_base[s];
          2: idx = m_base[s] + m_size[s] - 1;
          3: idx = m_base[s] + m_size[s];
          default: idx = $urandom_range(0, WORDS - 1);
        endcase
        if (idx < 0) idx = 0;
        do_chk(s, idx, "R6 random");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule